// File: doc/BRIEF.md
# Shared Local Bus Requester with Slave Preemption

This controller arbitrates on behalf of a bridge in which a DMA engine and a direct-slave engine use the same local bus. It drives one bus request line toward an external arbiter. A second qualifier line marks a request as made for a slave access. The controller also drives an enable for the local bus drivers. It watches the arbiter's grant acknowledge, and whichever engine currently owns the bus learns from a go signal that it may move data.

Slave accesses win over DMA. If a slave access becomes pending while DMA holds the bus, DMA may finish at most a fixed number of further word beats. The controller then releases the bus completely and waits for the grant to drop. After that it requests again with the slave qualifier set.

After each DMA release, a pause timer loads from a programmable value. DMA may not ask for the bus again until that timer has counted down to zero. Slave requests do not wait for the pause timer.

Top module: `slv_dma_req`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, bus_req, slv_qual, drv_en, dma_go and slv_go are all low.
- R2: From idle, with grant low, the pause timer at zero, no slave pending and dma_req high, bus_req rises at the next clock edge while slv_qual stays low. dma_go and drv_en follow once grant is high.
- R3: drv_en is high only while both gnt and bus_req are high. It falls in the same cycle that gnt drops, even if the bus has not been released.
- R4: While DMA owns the bus and slv_req is high, DMA is allowed at most BEATS (default 2) dma_beat pulses. At the clock edge that counts the last of them, bus_req falls.
- R5: bus_req never rises in a cycle that follows a cycle with gnt high. After any release, a new request waits until gnt has been low for one cycle.
- R6: If slv_req is high in idle with grant low, bus_req and slv_qual rise together at the next edge, even when dma_req is also high. slv_qual is never high without bus_req.
- R7: slv_done while the slave owns the bus drops bus_req and slv_qual at the next edge.
- R8: Each DMA release, whether caused by dma_done or by preemption, loads the pause timer from pause_val. The timer then decrements once per clock. A DMA request is made only when the timer reads zero, so with pause_val = N a DMA re-request cannot occur sooner than N+1 clocks after the release.
- R9: A pending slave request is made regardless of the pause timer value.
- R10: dma_done while DMA owns the bus drops bus_req at the next edge. A slave release does not reload the pause timer.
- R11: dma_go is high only while DMA owns the bus and gnt is high. slv_go is high only while the slave owns the bus and gnt is high. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_beat | input | 1 | DMA moved one word this cycle |
| dma_done | input | 1 | DMA transfer finished |
| slv_req | input | 1 | Direct-slave access pending, held until served |
| slv_done | input | 1 | Slave transfer finished |
| gnt | input | 1 | Grant acknowledge from the arbiter |
| pause_val | input | PW | Pause timer reload value |
| bus_req | output | 1 | Local bus request |
| slv_qual | output | 1 | Marks the request as a slave request |
| drv_en | output | 1 | Enable for the local bus drivers |
| dma_go | output | 1 | DMA may transfer |
| slv_go | output | 1 | Slave may transfer |

## Verification
The state is registered and the outputs decode from it, so bus_req and slv_qual answer a request input one clock edge after it is applied. drv_en, dma_go and slv_go also follow the present gnt without any register in between. The bench applies inputs one time unit after a rising edge and then waits through the next rising edge. Every checked result is read one time unit after that edge, so each result is exactly one edge old. The combinational drop of drv_en on gnt (R3) is checked one time unit after gnt changes, with no clock edge in between. Pause-timer checks count the idle cycles before the re-request edge by hand.

// File: rtl/slv_dma_req.sv
module slv_dma_req #(
  parameter int PW    = 8,
  parameter int BEATS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic          dma_beat,
  input  logic          dma_done,
  input  logic          slv_req,
  input  logic          slv_done,
  input  logic          gnt,
  input  logic [PW-1:0] pause_val,
  output logic          bus_req,
  output logic          slv_qual,
  output logic          drv_en,
  output logic          dma_go,
  output logic          slv_go
);
  localparam int CW = $clog2(BEATS + 1);

  typedef enum logic [2:0] {IDLE, DREQ, DOWN, SREQ, SOWN, RELW} st_t;

  st_t           state, nxt;
  logic [PW-1:0] pause_cnt;
  logic [CW-1:0] beat_cnt;
  logic          dma_rel;

  assign dma_rel = (state == DOWN) &&
                   (dma_done || (slv_req && dma_beat && beat_cnt == CW'(BEATS - 1)));

  always_comb begin
    nxt = state;
    unique case (state)
      IDLE: if (!gnt) begin
              if (slv_req)                          nxt = SREQ;
              else if (dma_req && pause_cnt == '0)  nxt = DREQ;
            end
      DREQ: if (gnt) nxt = DOWN;
      DOWN: if (dma_rel) nxt = RELW;
      SREQ: if (gnt) nxt = SOWN;
      SOWN: if (slv_done) nxt = RELW;
      RELW: if (!gnt) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      pause_cnt <= '0;
      beat_cnt  <= '0;
    end else begin
      state <= nxt;
      if (dma_rel)               pause_cnt <= pause_val;
      else if (pause_cnt != '0)  pause_cnt <= pause_cnt - 1'b1;
      if (state != DOWN)             beat_cnt <= '0;
      else if (slv_req && dma_beat)  beat_cnt <= beat_cnt + 1'b1;
    end
  end

  assign bus_req  = (state == DREQ) || (state == DOWN) || (state == SREQ) || (state == SOWN);
  assign slv_qual = (state == SREQ) || (state == SOWN);
  assign dma_go   = (state == DOWN) && gnt;
  assign slv_go   = (state == SOWN) && gnt;
  assign drv_en   = dma_go || slv_go;
endmodule

// File: rtl/slv_dma_req_chk.sv
module slv_dma_req_chk #(
  parameter int PW    = 8,
  parameter int BEATS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_beat,
  input logic          slv_req,
  input logic          slv_done,
  input logic          gnt,
  input logic          bus_req,
  input logic          slv_qual,
  input logic          drv_en,
  input logic          dma_go,
  input logic          slv_go,
  input logic [PW-1:0] pause_cnt
);
  localparam int KW = $clog2(BEATS + 2);
  logic [KW-1:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ck_cnt <= '0;
    else if (!dma_go)                  ck_cnt <= '0;
    else if (slv_req && dma_beat)      ck_cnt <= ck_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!bus_req && !slv_qual && !drv_en);
  end

  assert_en_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (gnt && bus_req));
  assert_yield_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_go && slv_req && dma_beat && ck_cnt == KW'(BEATS - 1)) |=> !bus_req);
  assert_req_after_gnt_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(gnt));
  assert_qual_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slv_qual |-> bus_req);
  assert_slave_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_go && slv_done) |=> (!bus_req && !slv_qual));
  assert_pause_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && !slv_qual) |-> ($past(pause_cnt) == '0));
  assert_go_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_go && slv_go));
endmodule

bind slv_dma_req slv_dma_req_chk #(.PW(PW), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_beat(dma_beat), .slv_req(slv_req),
  .slv_done(slv_done), .gnt(gnt), .bus_req(bus_req), .slv_qual(slv_qual),
  .drv_en(drv_en), .dma_go(dma_go), .slv_go(slv_go), .pause_cnt(pause_cnt)
);

// File: tb/sim_slv_dma_req.sv
module sim_slv_dma_req;
  localparam int CLK_P = 10;
  localparam int NV = 18;
  // {slv_req,slv_done,dma_req,dma_beat,dma_done,gnt} , {bus_req,slv_qual,drv_en,dma_go,slv_go}
  localparam logic [10:0] VEC [NV] = '{
    {6'b001000, 5'b10000},  // R2 request
    {6'b001001, 5'b10110},  // R11 DMA owns
    {6'b001101, 5'b10110},
    {6'b101001, 5'b10110},  // R4 slave pending
    {6'b101101, 5'b10110},  // R4 first beat
    {6'b101101, 5'b00000},  // R4 second beat releases
    {6'b100001, 5'b00000},  // R5 wait gnt low
    {6'b100000, 5'b00000},
    {6'b101000, 5'b11000},  // R6 slave wins over DMA
    {6'b100001, 5'b11101},  // R11 slave owns
    {6'b010001, 5'b00000},  // R7 slave done
    {6'b001000, 5'b00000},
    {6'b001000, 5'b10000},  // R10 no reload after slave
    {6'b001001, 5'b10110},
    {6'b001011, 5'b00000},  // R10 dma_done releases
    {6'b001000, 5'b00000},  // R8 timer 1
    {6'b001000, 5'b00000},  // R8 timer 0
    {6'b001000, 5'b10000}   // R8 re-request
  };

  logic clk = 0, rst_n = 0;
  logic dma_req = 0, dma_beat = 0, dma_done = 0, slv_req = 0, slv_done = 0, gnt = 0;
  logic [7:0] pause_val = 8'd2;
  logic bus_req, slv_qual, drv_en, dma_go, slv_go;
  int total = 0, bad = 0;

  slv_dma_req u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {bus_req, slv_qual, drv_en, dma_go, slv_go};
  endfunction

  task automatic set_in(logic [5:0] v);
    {slv_req, slv_done, dma_req, dma_beat, dma_done, gnt} = v;
  endtask

  task automatic restart(logic [7:0] pv);
    set_in(6'b0); pause_val = pv;
    rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic to_dma_own();
    set_in(6'b001000); tick();
    set_in(6'b001001); tick();
  endtask

  initial begin
    #(CLK_P * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    chk("R1 during reset", outs(), 5'b00000);
    tick(); rst_n = 1; tick();
    chk("R1 after reset", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][10:5]);
      tick();
      chk($sformatf("vector %0d", i), outs(), VEC[i][4:0]);
    end

    // R3: drv_en falls with gnt, no clock edge
    restart(8'd0); to_dma_own();
    chk("R3 own", outs(), 5'b10110);
    gnt = 0; #1;
    chk("R3 gnt drop", outs(), 5'b10000);

    // R4: gap between beats keeps bus, second beat releases
    restart(8'd0); to_dma_own();
    set_in(6'b101101); tick();
    chk("R4 one beat", outs(), 5'b10110);
    set_in(6'b101001); tick();
    chk("R4 idle beat", outs(), 5'b10110);
    set_in(6'b101101); tick();
    chk("R4 release", outs(), 5'b00000);

    // R9: slave not held by pause timer
    restart(8'd5); to_dma_own();
    set_in(6'b001011); tick();
    set_in(6'b100000); tick();
    chk("R9 idle", outs(), 5'b00000);
    tick();
    chk("R9 slave request", outs(), 5'b11000);

    // R5: no request while gnt stays high after release
    set_in(6'b100001); tick();
    set_in(6'b010001); tick();
    set_in(6'b100001);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 held off", outs(), 5'b00000);
    end
    gnt = 0; tick();
    chk("R5 idle", outs(), 5'b00000);
    tick();
    chk("R6 slave request", outs(), 5'b11000);

    // R8: zero pause re-requests at once
    restart(8'd0); to_dma_own();
    set_in(6'b001011); tick();
    set_in(6'b001000); tick();
    tick();
    chk("R8 zero pause", outs(), 5'b10000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule